// File: doc/BRIEF.md
# Spread-FSK Tone Synthesizer with Serial Bit Scheduler

This block produces the digital transmit tones of a spread-FSK power-line modulator by direct digital synthesis. Two programmable frequency-step words, one for the "space" tone (data 0) and one for the "mark" tone (data 1), set the two tones. In transmit mode a byte taken from a host data register is sent most significant bit first, one bit per bit period. For each bit a phase accumulator advances every clock by the step word that the bit selects, and its upper bits address a quarter-wave sine table.

A host microcontroller drives the block through an 8-bit register port and one interrupt line. A pre-byte interrupt fires one bit period before each byte boundary. This gives the host time to supply the next byte, or to leave transmit mode so that the byte in flight becomes the last one. In receive mode the bit scheduler is idle. Two free-running accumulators then deliver sine and cosine samples of both tones at once, for a downstream mixer.

Top module: `sfsk_tone_gen`

## Requirements
- R1: After a synchronous active-low reset, all host registers read 0, and tx_en, irq, bit_clk, byte_clk and tx_sample are 0.
- R2: Host register map (3-bit address, written when host_we is high at a clock edge, read combinationally): 0 transmit data byte; 1 control, bit 0 = 1 selects transmit; 2 status, bit 0 = pre-byte flag; 3/4 space step low/high byte; 5/6 mark step low/high byte. Each reads back what was last written. The status register is the exception and is covered by R8.
- R3: A sample is the signed lookup of the top LUT_W phase bits p. With Q = p[LUT_W-3:0], N = 2^LUT_W, A = 2^(AMP_W-1)-1 and a = 2k+1, the magnitude table holds m[k] = floor(4·A·a(N−a) / (5N²/4 − a(N−a))). The index is Q, or the bitwise inverse of Q when p[LUT_W-2] is 1. The result is negated when p[LUT_W-1] is 1.
- R4: While tx_en is high, the transmit accumulator adds the mark step when tx_bit is 1 and the space step when tx_bit is 0, on every clock. It is never reset at bit boundaries, so phase is continuous. tx_sample is the R3 lookup of the accumulator. While tx_en is low, the accumulator is held at 0 and tx_sample is 0.
- R5: In the first cycle in which the control bit reads 1 while tx_en is low, byte_clk is high and the data byte is captured. tx_en is high from the next cycle on.
- R6: Bits leave most significant first, each for BIT_CYCLES clocks on tx_bit. bit_clk is high exactly in the last clock of each bit.
- R7: At the end of the eighth bit of a byte, if the control bit is 1, byte_clk is high and the next byte is taken from the data register. Writes to the data register during a byte do not change that byte.
- R8: The pre-byte flag is set at the end of the seventh bit, so it reads 1 exactly one bit period before byte_clk. irq follows the flag. Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged.
- R9: Clearing the control bit takes effect only at the next byte end: the current byte finishes, no byte_clk is issued, and tx_en falls.
- R10: While tx_en is low and the control bit is 0, a space accumulator and a mark accumulator each add their own step on every clock. rx_space_i and rx_mark_i carry the R3 lookup of their phase, and rx_space_q and rx_mark_q carry the lookup with a quarter turn added. Outside this mode both accumulators are held at 0 and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 8 | Host read data for host_addr |
| irq | output | 1 | Pre-byte interrupt |
| tx_en | output | 1 | Transmitter active |
| tx_bit | output | 1 | Bit currently transmitted |
| bit_clk | output | 1 | Last-cycle-of-bit pulse |
| byte_clk | output | 1 | Byte load pulse |
| tx_sample | output | AMP_W | Signed transmit tone sample |
| rx_space_i | output | AMP_W | Space tone sine sample |
| rx_space_q | output | AMP_W | Space tone cosine sample |
| rx_mark_i | output | AMP_W | Mark tone sine sample |
| rx_mark_q | output | AMP_W | Mark tone cosine sample |

## Verification
The bench builds the block with BIT_CYCLES = 6 and the default 16-bit phase, 8-bit table address and 8-bit amplitude. A three-byte transmission then takes under 150 cycles, and every bit boundary, byte reload and pre-byte interrupt falls well inside the run. Six-cycle bits still leave room for the host to answer the interrupt before the byte ends, so the test exercises the reload and the delayed stop at a byte end. With the default widths, the chosen step words sweep all four quadrants of the table in both the transmit and receive phases.

// File: rtl/sfsk_pkg.sv
// Shared constants for the spread-FSK tone synthesizer.
// Assumes a 3-bit host address space; the table function is evaluated
// only at elaboration with constant arguments.
package sfsk_pkg;

    localparam logic [2:0] ADR_TXDATA = 3'd0;
    localparam logic [2:0] ADR_CTRL   = 3'd1;
    localparam logic [2:0] ADR_STATUS = 3'd2;
    localparam logic [2:0] ADR_SP_LO  = 3'd3;
    localparam logic [2:0] ADR_SP_HI  = 3'd4;
    localparam logic [2:0] ADR_MK_LO  = 3'd5;
    localparam logic [2:0] ADR_MK_HI  = 3'd6;

    // Quarter-wave magnitude at entry idx (rational sine approximation,
    // sampled at half-entry offsets so the quarter is symmetric).
    function automatic int qmag(input int idx, input int lut_w, input int amp_w);
        longint n;
        longint a;
        longint p;
        longint amp;
        n   = longint'(1) << lut_w;
        a   = 2 * longint'(idx) + 1;
        p   = a * (n - a);
        amp = (longint'(1) << (amp_w - 1)) - 1;
        return int'((amp * 4 * p) / ((5 * n * n) / 4 - p));
    endfunction

endpackage

// File: rtl/sfsk_sine_lut.sv
// Quarter-wave sine lookup: maps a phase word to a signed sample.
// Assumes LUT_W >= 3; the table is generated from sfsk_pkg::qmag.
module sfsk_sine_lut #(
    parameter int LUT_W = 8,
    parameter int AMP_W = 8
) (
    input  logic        [LUT_W-1:0] phase,
    output logic signed [AMP_W-1:0] sample
);
    localparam int QW  = LUT_W - 2;
    localparam int QTR = 1 << QW;

    logic [AMP_W-2:0] mag_tab [QTR];
    logic [QW-1:0]    idx;
    logic [AMP_W-2:0] mag;

    for (genvar g = 0; g < QTR; g++) begin : g_tab
        assign mag_tab[g] = (AMP_W-1)'(sfsk_pkg::qmag(g, LUT_W, AMP_W));
    end

    // Fold the phase into one quadrant, look up, then apply the sign.
    always_comb begin
        idx    = phase[LUT_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];
        mag    = mag_tab[idx];
        sample = phase[LUT_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/sfsk_phase_acc.sv
// Phase accumulator: adds the step word every clock unless cleared.
// Assumes clr is synchronous; only the top OUT_W bits leave the module.
module sfsk_phase_acc #(
    parameter int PHASE_W = 16,
    parameter int OUT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [PHASE_W-1:0] step,
    output logic [OUT_W-1:0]   phase_top
);
    logic [PHASE_W-1:0] acc;

    // Accumulate the step word, or hold at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else               acc <= acc + step;
    end

    assign phase_top = acc[PHASE_W-1 -: OUT_W];

    // R4
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> acc == $past(acc + step));
endmodule

// File: rtl/sfsk_host_regs.sv
// Host register file: data byte, mode bit, step words, pre-byte flag.
// Assumes a single write port; a set request wins over a clear.
module sfsk_host_regs #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         addr,
    input  logic [7:0]         wdata,
    input  logic               we,
    input  logic               set_flag,
    output logic [7:0]         rdata,
    output logic [7:0]         tx_data,
    output logic               tx_mode,
    output logic [PHASE_W-1:0] space_step,
    output logic [PHASE_W-1:0] mark_step,
    output logic               flag
);
    import sfsk_pkg::*;

    logic [15:0] sp_q;
    logic [15:0] mk_q;
    logic        clr_req;

    assign clr_req = we && (addr == ADR_STATUS) && wdata[0];

    // Store host writes into the data, control and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_mode <= 1'b0;
            sp_q    <= '0;
            mk_q    <= '0;
        end else if (we) begin
            case (addr)
                ADR_TXDATA: tx_data    <= wdata;
                ADR_CTRL:   tx_mode    <= wdata[0];
                ADR_SP_LO:  sp_q[7:0]  <= wdata;
                ADR_SP_HI:  sp_q[15:8] <= wdata;
                ADR_MK_LO:  mk_q[7:0]  <= wdata;
                ADR_MK_HI:  mk_q[15:8] <= wdata;
                default: ;
            endcase
        end
    end

    // Pre-byte flag: set by the scheduler, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        case (addr)
            ADR_TXDATA: rdata = tx_data;
            ADR_CTRL:   rdata = {7'd0, tx_mode};
            ADR_STATUS: rdata = {7'd0, flag};
            ADR_SP_LO:  rdata = sp_q[7:0];
            ADR_SP_HI:  rdata = sp_q[15:8];
            ADR_MK_LO:  rdata = mk_q[7:0];
            ADR_MK_HI:  rdata = mk_q[15:8];
            default:    rdata = 8'd0;
        endcase
    end

    assign space_step = PHASE_W'(sp_q) << (PHASE_W - 16);
    assign mark_step  = PHASE_W'(mk_q) << (PHASE_W - 16);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_flag) |=> !flag);
    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_flag));
endmodule

// File: rtl/sfsk_tx_serial.sv
// Bit scheduler: loads bytes, shifts them out MSB first, times the bits,
// and raises the byte and pre-byte events. Assumes BIT_CYCLES >= 1.
module sfsk_tx_serial #(
    parameter int BIT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_mode,
    input  logic [7:0] tx_data,
    output logic       tx_run,
    output logic       tx_bit,
    output logic       bit_clk,
    output logic       byte_clk,
    output logic       pre_byte
);
    localparam int CW = $clog2(BIT_CYCLES + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cyc;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          start;
    logic          last_bit;

    assign start    = tx_mode && !tx_run;
    assign last_bit = (bidx == 3'd7);
    assign bit_clk  = tx_run && (cyc == CYC_LAST);
    assign byte_clk = start || (bit_clk && last_bit && tx_mode);
    assign pre_byte = bit_clk && (bidx == 3'd6);
    assign tx_bit   = shreg[7];

    // Sequence start, bit timing, shifting, reload and stop at a byte end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_run <= 1'b0;
            cyc    <= '0;
            bidx   <= '0;
            shreg  <= '0;
        end else if (start) begin
            tx_run <= 1'b1;
            cyc    <= '0;
            bidx   <= '0;
            shreg  <= tx_data;
        end else if (tx_run) begin
            if (bit_clk) begin
                cyc <= '0;
                if (last_bit) begin
                    if (tx_mode) begin
                        shreg <= tx_data;
                        bidx  <= '0;
                    end else begin
                        tx_run <= 1'b0;
                    end
                end else begin
                    shreg <= {shreg[6:0], 1'b0};
                    bidx  <= bidx + 3'd1;
                end
            end else begin
                cyc <= cyc + CW'(1);
            end
        end
    end

    if (BIT_CYCLES > 1) begin : g_gap
        // R6
        bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bit_clk |=> !bit_clk);
    end
    // R7
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_clk |=> (tx_bit == $past(tx_data[7])));
    // R9
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_run) |-> ($past(bit_clk) && !$past(tx_mode)));
endmodule

// File: rtl/sfsk_tone_gen.sv
// Spread-FSK tone synthesizer top: host registers, bit scheduler, one
// transmit accumulator and two receive accumulators with sine/cosine
// lookups. Assumes PHASE_W >= 16 and PHASE_W >= LUT_W.
module sfsk_tone_gen #(
    parameter int PHASE_W    = 16,
    parameter int LUT_W      = 8,
    parameter int AMP_W      = 8,
    parameter int BIT_CYCLES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              host_addr,
    input  logic [7:0]              host_wdata,
    input  logic                    host_we,
    output logic [7:0]              host_rdata,
    output logic                    irq,
    output logic                    tx_en,
    output logic                    tx_bit,
    output logic                    bit_clk,
    output logic                    byte_clk,
    output logic signed [AMP_W-1:0] tx_sample,
    output logic signed [AMP_W-1:0] rx_space_i,
    output logic signed [AMP_W-1:0] rx_space_q,
    output logic signed [AMP_W-1:0] rx_mark_i,
    output logic signed [AMP_W-1:0] rx_mark_q
);
    localparam logic [LUT_W-1:0] QUARTER = LUT_W'(1) << (LUT_W - 2);

    logic [7:0]         tx_data;
    logic               tx_mode;
    logic               pre_byte;
    logic               rx_on;
    logic [PHASE_W-1:0] steps [2];
    logic [PHASE_W-1:0] tx_step;
    logic [LUT_W-1:0]   tx_phase;
    logic signed [AMP_W-1:0] tx_raw;
    logic signed [AMP_W-1:0] rx_sin [2];
    logic signed [AMP_W-1:0] rx_cos [2];

    sfsk_host_regs #(.PHASE_W(PHASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(host_addr), .wdata(host_wdata),
        .we(host_we), .set_flag(pre_byte), .rdata(host_rdata),
        .tx_data(tx_data), .tx_mode(tx_mode), .space_step(steps[0]),
        .mark_step(steps[1]), .flag(irq)
    );

    sfsk_tx_serial #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tx_data(tx_data),
        .tx_run(tx_en), .tx_bit(tx_bit), .bit_clk(bit_clk),
        .byte_clk(byte_clk), .pre_byte(pre_byte)
    );

    // Transmit tone: the current bit selects which step word drives the phase.
    assign tx_step = tx_bit ? steps[1] : steps[0];

    sfsk_phase_acc #(.PHASE_W(PHASE_W), .OUT_W(LUT_W)) u_tx_acc (
        .clk(clk), .rst_n(rst_n), .clr(!tx_en), .step(tx_step),
        .phase_top(tx_phase)
    );

    sfsk_sine_lut #(.LUT_W(LUT_W), .AMP_W(AMP_W)) u_tx_lut (
        .phase(tx_phase), .sample(tx_raw)
    );

    assign tx_sample = tx_en ? tx_raw : '0;

    // Receive tones: index 0 is space, index 1 is mark.
    assign rx_on = !tx_mode && !tx_en;

    for (genvar t = 0; t < 2; t++) begin : g_rx
        logic [LUT_W-1:0] ph;
        logic [LUT_W-1:0] ph_q;

        sfsk_phase_acc #(.PHASE_W(PHASE_W), .OUT_W(LUT_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(!rx_on), .step(steps[t]),
            .phase_top(ph)
        );

        assign ph_q = ph + QUARTER;

        sfsk_sine_lut #(.LUT_W(LUT_W), .AMP_W(AMP_W)) u_sin (
            .phase(ph), .sample(rx_sin[t])
        );
        sfsk_sine_lut #(.LUT_W(LUT_W), .AMP_W(AMP_W)) u_cos (
            .phase(ph_q), .sample(rx_cos[t])
        );
    end

    assign rx_space_i = rx_on ? rx_sin[0] : '0;
    assign rx_space_q = rx_on ? rx_cos[0] : '0;
    assign rx_mark_i  = rx_on ? rx_sin[1] : '0;
    assign rx_mark_q  = rx_on ? rx_cos[1] : '0;
endmodule

// File: tb/sim_sfsk_tone_gen.sv
module sim_sfsk_tone_gen;
    localparam int B = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;
    logic       irq, tx_en, tx_bit, bit_clk, byte_clk;
    logic signed [7:0] tx_sample, rx_space_i, rx_space_q, rx_mark_i, rx_mark_q;

    sfsk_tone_gen #(.BIT_CYCLES(B)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .irq(irq), .tx_en(tx_en),
        .tx_bit(tx_bit), .bit_clk(bit_clk), .byte_clk(byte_clk),
        .tx_sample(tx_sample), .rx_space_i(rx_space_i), .rx_space_q(rx_space_q),
        .rx_mark_i(rx_mark_i), .rx_mark_q(rx_mark_q)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [6:0]  magt [64];
    logic [7:0]  exp_q [$];
    logic [15:0] sp_m = '0, mk_m = '0;
    logic [15:0] tacc = '0, racc_s = '0, racc_m = '0;
    logic        mode_m = 1'b0;
    logic        prev_irq = 1'b0;
    int          n = 0;
    int          bytes_done = 0;

    // Magnitude table from the R3 formula (LUT_W = 8, AMP_W = 8).
    initial begin
        for (int k = 0; k < 64; k++) begin
            longint a, p;
            a = 2 * k + 1;
            p = a * (256 - a);
            magt[k] = 7'((127 * 4 * p) / (81920 - p));
        end
    end

    function automatic logic signed [7:0] exp_sin(input logic [7:0] ph);
        logic [5:0] ix;
        logic [6:0] m;
        ix = ph[6] ? ~ph[5:0] : ph[5:0];
        m  = magt[ix];
        return ph[7] ? -$signed({1'b0, m}) : $signed({1'b0, m});
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: one host write, model mirror updated after the write edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(posedge clk); #2;
        host_we = 1'b0;
        case (a)
            3'd1: mode_m = d[0];
            3'd3: sp_m[7:0] = d;
            3'd4: sp_m[15:8] = d;
            3'd5: mk_m[7:0] = d;
            3'd6: mk_m[15:8] = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #2;
        host_addr = a;
        #3;
        chk(host_rdata == e, req, host_rdata, e);
    endtask

    // Monitor / scoreboard: compares outputs against the model each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 queue", 0, 1);
                end else begin
                    int bi;
                    logic bv;
                    bit endb;
                    bi   = (n / B) % 8;
                    bv   = exp_q[0][7 - bi];
                    endb = (n % B) == B - 1;
                    chk(tx_bit == bv, "R6 tx_bit", tx_bit, bv);
                    chk(tx_sample == exp_sin(tacc[15:8]), "R4 tx_sample",
                        tx_sample, exp_sin(tacc[15:8]));
                    chk(bit_clk == endb, "R6 bit_clk", bit_clk, endb);
                    if (endb && bi == 7) begin
                        chk(byte_clk == mode_m, "R7 byte_clk", byte_clk, mode_m);
                        void'(exp_q.pop_front());
                        bytes_done++;
                    end else begin
                        chk(byte_clk == 1'b0, "R7 byte_clk idle", byte_clk, 0);
                    end
                    if (irq && !prev_irq)
                        chk((n % (8 * B)) == 7 * B, "R8 irq timing", n % (8 * B), 7 * B);
                    tacc = tacc + (bv ? mk_m : sp_m);
                    n++;
                end
            end else begin
                tacc = '0;
                n    = 0;
                chk(tx_sample == 0, "R4 idle sample", tx_sample, 0);
                chk(bit_clk == 1'b0, "R6 idle bit_clk", bit_clk, 0);
                chk(byte_clk == mode_m, "R5 start byte_clk", byte_clk, mode_m);
            end
            if (!tx_en && !mode_m) begin
                chk(rx_space_i == exp_sin(racc_s[15:8]), "R10 space i",
                    rx_space_i, exp_sin(racc_s[15:8]));
                chk(rx_space_q == exp_sin(racc_s[15:8] + 8'd64), "R10 space q",
                    rx_space_q, exp_sin(racc_s[15:8] + 8'd64));
                chk(rx_mark_i == exp_sin(racc_m[15:8]), "R10 mark i",
                    rx_mark_i, exp_sin(racc_m[15:8]));
                chk(rx_mark_q == exp_sin(racc_m[15:8] + 8'd64), "R10 mark q",
                    rx_mark_q, exp_sin(racc_m[15:8] + 8'd64));
                racc_s = racc_s + sp_m;
                racc_m = racc_m + mk_m;
            end else begin
                chk(rx_space_i == 0 && rx_space_q == 0 && rx_mark_i == 0 && rx_mark_q == 0,
                    "R10 rx off", rx_space_i, 0);
                racc_s = '0;
                racc_m = '0;
            end
            prev_irq = irq;
        end
    end

    // Watchdog.
    initial begin
        #(20 * 20000);
        chk(1'b0, "watchdog", 0, 1);
        finish_sim();
    end

    // Stimulus.
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 outputs in reset
        chk(tx_en == 0 && irq == 0 && byte_clk == 0 && bit_clk == 0, "R1 outputs",
            {tx_en, irq, byte_clk, bit_clk}, 0);
        chk(tx_sample == 0, "R1 tx_sample", tx_sample, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 regs");

        wr(3'd3, 8'h3C);
        wr(3'd4, 8'h0A);
        wr(3'd5, 8'h05);
        wr(3'd6, 8'h1F);
        rd(3'd3, 8'h3C, "R2 space lo");
        rd(3'd4, 8'h0A, "R2 space hi");
        rd(3'd5, 8'h05, "R2 mark lo");
        rd(3'd6, 8'h1F, "R2 mark hi");
        repeat (60) @(posedge clk);

        exp_q.push_back(8'hA5);
        wr(3'd0, 8'hA5);
        rd(3'd0, 8'hA5, "R2 data");
        wr(3'd1, 8'h01);
        rd(3'd1, 8'h01, "R2 ctrl");
        wr(3'd0, 8'hFF);   // R7: lands during byte 0, must not alter it

        wait (irq == 1'b1);
        exp_q.push_back(8'h3C);
        wr(3'd0, 8'h3C);
        wr(3'd2, 8'h00);
        rd(3'd2, 8'h01, "R8 write zero keeps flag");
        wr(3'd2, 8'h01);
        rd(3'd2, 8'h00, "R8 write one clears");
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq low", irq, 0);

        wait (irq == 1'b1);
        exp_q.push_back(8'h96);
        wr(3'd0, 8'h96);
        wr(3'd2, 8'h01);

        wait (irq == 1'b1);
        wr(3'd1, 8'h00);   // R9: stop after the byte in flight
        wr(3'd2, 8'h01);
        wait (tx_en == 1'b0);
        @(negedge clk);
        chk(bytes_done == 3, "R9 bytes sent", bytes_done, 3);
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        repeat (40) @(posedge clk);
        rd(3'd0, 8'h96, "R2 data final");
        finish_sim();
    end
endmodule